// File: doc/BRIEF.md
# Virtual Address Access Checker

This block sits between a load/store/fetch unit and an external translation lookaside buffer. For each request it takes a 32-bit virtual address, the kind of access (read, write or instruction fetch), the privilege level and three control bits: translation enable, shared-virtual mode and user store-queue block. It sorts the request into one of three routes: untranslated pass-through, translation through the TLB, or an address error.

On the translation route the block asks the external TLB for a lookup. It tells the TLB whether the address-space identifier must match. From the lookup outcome and the matched entry's size, permission and dirty flags it produces either a physical address or a single exception code.

The result appears one cycle after the request, with a valid strobe. Any TLB-class fault also records the faulting virtual address. It updates the upper part of a page-table-high register too, and that register's low ten bits are kept.

Top module: `va_access_chk`

## Requirements
- R1: A privileged read or write with bit 31 set passes through unchanged (physical = virtual, no exception) when the address is below 0xC0000000 or at or above 0xE0000000, whatever the translation enable says. A privileged fetch with bit 31 set below 0xC0000000 also passes.
- R2: A privileged fetch at or above 0xE0000000 gives an address error. Any user-mode access with bit 31 set gives an address error unless R3 lets it pass.
- R3: A user read or write in 0xE0000000..0xE3FFFFFF passes through when `ctl_sq_block` is 0. The same access with `ctl_sq_block` at 1 gives an address error, and so does a user fetch in that window.
- R4: With `ctl_at` at 0, every request that R1 to R3 do not settle passes through unchanged and asks for no lookup.
- R5: `tlb_lookup` is high in the same cycle as a request that needs translation (address bit 31 clear, or a privileged read/write/fetch in 0xC0000000..0xDFFFFFFF, with `ctl_at` at 1). While it is high, `tlb_asid_en` is high exactly when `ctl_sv` is 0 or the request is from user mode.
- R6: A translated request is faulted in this priority order: miss (`tlb_hit` 0), then multi-hit, then protection, then dirty. A miss reports miss-read for reads and fetches and miss-write for writes.
- R7: A translated write needs the writable flag in privileged mode. In user mode it needs both the writable flag and the user flag. Failing this reports protection-write.
- R8: A translated read or fetch in user mode to an entry whose user flag is 0 reports protection-read. In privileged mode the user flag does not matter.
- R9: A permitted translated write to an entry whose dirty flag is 0 reports initial-write.
- R10: A translation that does not fault returns (ppn AND mask) OR (va AND NOT mask). The mask clears the low 10, 12, 16 or 20 bits for size codes 0, 1, 2 and 3.
- R11: Miss, multi-hit, protection and initial-write faults load `fault_addr` with the full virtual address. The same faults set `pteh[31:10]` to va[31:10] and keep `pteh[9:0]`. Address errors and successful accesses change neither register. Outside a fault, `pteh_wr_en` loads `pteh` whole.
- R12: After reset `res_valid`, `res_exc`, `res_pa`, `fault_addr` and `pteh` are all zero.
- R13: `res_exc` is zero on success and otherwise has exactly one bit set. The bits are: 0 miss-read, 1 miss-write, 2 protection-read, 3 protection-write, 4 initial-write, 5 multi-hit, 6 address error. `res_pa` is zero whenever `res_exc` is non-zero. Each result arrives with `res_valid` on the cycle after its request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present this cycle |
| req_va | input | 32 | Virtual address |
| req_kind | input | 2 | 0 read, 1 write, 2 fetch |
| req_priv | input | 1 | 1 for privileged mode |
| ctl_at | input | 1 | Translation enable |
| ctl_sv | input | 1 | Shared-virtual mode (privileged lookups ignore ASID) |
| ctl_sq_block | input | 1 | Blocks user access to the store-queue window |
| tlb_lookup | output | 1 | Request needs a TLB lookup |
| tlb_asid_en | output | 1 | Lookup must match ASID on non-shared entries |
| tlb_hit | input | 1 | At least one entry matched |
| tlb_multi | input | 1 | More than one entry matched |
| tlb_ppn | input | 32 | Matched entry physical page base |
| tlb_size | input | 2 | Matched entry size code |
| tlb_user | input | 1 | Matched entry user-access flag |
| tlb_wr | input | 1 | Matched entry writable flag |
| tlb_dirty | input | 1 | Matched entry dirty flag |
| pteh_wr_en | input | 1 | Load `pteh` from `pteh_wr_data` |
| pteh_wr_data | input | 32 | Value for `pteh` |
| res_valid | output | 1 | Result strobe |
| res_pa | output | 32 | Physical address |
| res_exc | output | 7 | One-hot exception code |
| fault_addr | output | 32 | Last TLB-fault virtual address |
| pteh | output | 32 | Page-table-high register |

## Verification
The hardest cases are the ones where two fault causes are present at once. Examples are a multi-hit on an entry that also lacks permission, and a user write to a page that is both read-only and clean. Only the priority order decides those. The bench drives the TLB outcome pins directly, so it can set up conflicting conditions in a single request. It also preloads `pteh` with a distinctive low-bit pattern, then follows a fault with an address error, to show that the kept bits survive and that the error leaves both fault registers alone.

// File: rtl/va_chk_pkg.sv
package va_chk_pkg;

    localparam int VA_W  = 32;
    localparam int EXC_W = 7;

    localparam int EXC_MISS_RD = 0;
    localparam int EXC_MISS_WR = 1;
    localparam int EXC_PROT_RD = 2;
    localparam int EXC_PROT_WR = 3;
    localparam int EXC_INIT_WR = 4;
    localparam int EXC_MULTI   = 5;
    localparam int EXC_ADDR    = 6;

    localparam logic [EXC_W-1:0] TLB_FAULT_SET = EXC_W'(7'b0111111);

    typedef enum logic [1:0] {
        ACC_READ  = 2'd0,
        ACC_WRITE = 2'd1,
        ACC_EXEC  = 2'd2
    } acc_kind_e;

    typedef enum logic [1:0] {
        RT_PASS = 2'd0,
        RT_XLAT = 2'd1,
        RT_AERR = 2'd2
    } route_e;

    typedef struct packed {
        logic            hit;
        logic            multi;
        logic [VA_W-1:0] ppn;
        logic [1:0]      size;
        logic            user;
        logic            wr;
        logic            dirty;
    } tlb_info_t;

    typedef struct packed {
        logic [EXC_W-1:0] exc;
        logic [VA_W-1:0]  pa;
    } verdict_t;

    function automatic logic [VA_W-1:0] page_mask(input logic [1:0] sz);
        logic [VA_W-1:0] m;
        case (sz)
            2'd0:    m = 32'hFFFF_FC00;
            2'd1:    m = 32'hFFFF_F000;
            2'd2:    m = 32'hFFFF_0000;
            default: m = 32'hFFF0_0000;
        endcase
        return m;
    endfunction

endpackage

// File: rtl/va_route_dec.sv
module va_route_dec
    import va_chk_pkg::*;
(
    input  logic [VA_W-1:0] va,
    input  acc_kind_e       kind,
    input  logic            priv,
    input  logic            xlat_en,
    input  logic            sq_block,
    output route_e          route
);
    logic hi_half;
    logic below_c0;
    logic top_e0;
    logic sq_win;

    assign hi_half  = va[VA_W-1];
    assign below_c0 = (va[VA_W-1:VA_W-2] == 2'b10);
    assign top_e0   = (va[VA_W-1:VA_W-3] == 3'b111);
    assign sq_win   = (va[VA_W-1:VA_W-6] == 6'b111000);

    always_comb begin
        route_e cand;
        cand = xlat_en ? RT_XLAT : RT_PASS;
        if (!hi_half) begin
            route = cand;
        end else if (priv) begin
            if (kind == ACC_EXEC) begin
                if (below_c0)    route = RT_PASS;
                else if (top_e0) route = RT_AERR;
                else             route = cand;
            end else begin
                route = (below_c0 || top_e0) ? RT_PASS : cand;
            end
        end else begin
            route = (kind != ACC_EXEC && sq_win && !sq_block) ? RT_PASS : RT_AERR;
        end
    end
endmodule

// File: rtl/va_fault_eval.sv
module va_fault_eval
    import va_chk_pkg::*;
(
    input  logic [VA_W-1:0] va,
    input  acc_kind_e       kind,
    input  logic            priv,
    input  tlb_info_t       tlb,
    output verdict_t        verdict
);
    logic            is_wr;
    logic            wr_ok;
    logic            rd_ok;
    logic [VA_W-1:0] mask;

    assign is_wr = (kind == ACC_WRITE);
    assign wr_ok = priv ? tlb.wr : (tlb.wr && tlb.user);
    assign rd_ok = priv || tlb.user;
    assign mask  = page_mask(tlb.size);

    always_comb begin
        verdict.exc = '0;
        verdict.pa  = '0;
        if (!tlb.hit) begin
            verdict.exc[is_wr ? EXC_MISS_WR : EXC_MISS_RD] = 1'b1;
        end else if (tlb.multi) begin
            verdict.exc[EXC_MULTI] = 1'b1;
        end else if (is_wr && !wr_ok) begin
            verdict.exc[EXC_PROT_WR] = 1'b1;
        end else if (is_wr && !tlb.dirty) begin
            verdict.exc[EXC_INIT_WR] = 1'b1;
        end else if (!is_wr && !rd_ok) begin
            verdict.exc[EXC_PROT_RD] = 1'b1;
        end else begin
            verdict.pa = (tlb.ppn & mask) | (va & ~mask);
        end
    end
endmodule

// File: rtl/va_access_chk.sv
module va_access_chk
    import va_chk_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic [31:0]       req_va,
    input  logic [1:0]        req_kind,
    input  logic              req_priv,
    input  logic              ctl_at,
    input  logic              ctl_sv,
    input  logic              ctl_sq_block,
    output logic              tlb_lookup,
    output logic              tlb_asid_en,
    input  logic              tlb_hit,
    input  logic              tlb_multi,
    input  logic [31:0]       tlb_ppn,
    input  logic [1:0]        tlb_size,
    input  logic              tlb_user,
    input  logic              tlb_wr,
    input  logic              tlb_dirty,
    input  logic              pteh_wr_en,
    input  logic [31:0]       pteh_wr_data,
    output logic              res_valid,
    output logic [31:0]       res_pa,
    output logic [6:0]        res_exc,
    output logic [31:0]       fault_addr,
    output logic [31:0]       pteh
);
    localparam int KEEP_LO = 10;

    acc_kind_e kind;
    route_e    route;
    tlb_info_t tlb;
    verdict_t  xv;
    verdict_t  nxt;
    logic      tlb_fault;

    assign kind = acc_kind_e'(req_kind);
    assign tlb  = '{hit: tlb_hit, multi: tlb_multi, ppn: tlb_ppn, size: tlb_size,
                    user: tlb_user, wr: tlb_wr, dirty: tlb_dirty};

    va_route_dec u_route (
        .va       (req_va),
        .kind     (kind),
        .priv     (req_priv),
        .xlat_en  (ctl_at),
        .sq_block (ctl_sq_block),
        .route    (route)
    );

    va_fault_eval u_fault (
        .va      (req_va),
        .kind    (kind),
        .priv    (req_priv),
        .tlb     (tlb),
        .verdict (xv)
    );

    assign tlb_lookup  = req_valid && (route == RT_XLAT);
    assign tlb_asid_en = tlb_lookup && (!ctl_sv || !req_priv);

    always_comb begin
        nxt = '0;
        case (route)
            RT_PASS: nxt.pa = req_va;
            RT_AERR: nxt.exc[EXC_ADDR] = 1'b1;
            default: nxt = xv;
        endcase
    end

    assign tlb_fault = tlb_lookup && ((xv.exc & TLB_FAULT_SET) != '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            res_valid  <= 1'b0;
            res_pa     <= '0;
            res_exc    <= '0;
            fault_addr <= '0;
            pteh       <= '0;
        end else begin
            res_valid <= req_valid;
            if (req_valid) begin
                res_pa  <= nxt.pa;
                res_exc <= nxt.exc;
            end
            if (tlb_fault) begin
                fault_addr <= req_va;
                pteh       <= {req_va[VA_W-1:KEEP_LO], pteh[KEEP_LO-1:0]};
            end else if (pteh_wr_en) begin
                pteh <= pteh_wr_data;
            end
        end
    end
endmodule

// File: rtl/va_access_chk_sva.sv
module va_access_chk_sva (
    input logic        clk,
    input logic        rst,
    input logic        req_valid,
    input logic [31:0] req_va,
    input logic [1:0]  req_kind,
    input logic        req_priv,
    input logic        ctl_at,
    input logic        ctl_sv,
    input logic        tlb_lookup,
    input logic        tlb_asid_en,
    input logic        res_valid,
    input logic [31:0] res_pa,
    input logic [6:0]  res_exc,
    input logic [31:0] fault_addr,
    input logic [31:0] pteh
);
    // R13
    exc_onehot_chk: assert property (@(posedge clk) disable iff (rst)
        res_valid |-> $onehot0(res_exc));

    // R1
    priv_bypass_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_priv && req_kind != 2'd2 && req_va[31] &&
         (!req_va[30] || req_va[31:29] == 3'b111))
        |=> (res_valid && res_exc == 7'd0 && res_pa == $past(req_va)));

    // R2
    user_exec_err_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !req_priv && req_va[31] && req_kind == 2'd2) |=> res_exc[6]);

    // R5
    asid_en_chk: assert property (@(posedge clk) disable iff (rst)
        (tlb_lookup && !req_priv) |-> tlb_asid_en);

    // R4
    no_lookup_off_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !ctl_at) |-> !tlb_lookup);

    // R11
    aerr_keeps_fault_chk: assert property (@(posedge clk) disable iff (rst)
        (res_valid && res_exc[6]) |-> ($stable(fault_addr) && $stable(pteh)));

    // R11
    pteh_tracks_fault_chk: assert property (@(posedge clk) disable iff (rst)
        (res_valid && res_exc[5:0] != 6'd0) |-> (pteh[31:10] == fault_addr[31:10]));

    // R5
    sv_priv_chk: assert property (@(posedge clk) disable iff (rst)
        (tlb_lookup && req_priv && !ctl_sv) |-> tlb_asid_en);
endmodule

bind va_access_chk va_access_chk_sva u_sva (
    .clk        (clk),
    .rst        (rst),
    .req_valid  (req_valid),
    .req_va     (req_va),
    .req_kind   (req_kind),
    .req_priv   (req_priv),
    .ctl_at     (ctl_at),
    .ctl_sv     (ctl_sv),
    .tlb_lookup (tlb_lookup),
    .tlb_asid_en(tlb_asid_en),
    .res_valid  (res_valid),
    .res_pa     (res_pa),
    .res_exc    (res_exc),
    .fault_addr (fault_addr),
    .pteh       (pteh)
);

// File: tb/va_access_chk_bench.sv
module va_access_chk_bench;
    localparam time CLK_P = 20ns;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic [31:0] req_va = '0;
    logic [1:0]  req_kind = '0;
    logic        req_priv = 1'b0;
    logic        ctl_at = 1'b0, ctl_sv = 1'b0, ctl_sq_block = 1'b0;
    logic        tlb_lookup, tlb_asid_en;
    logic        tlb_hit = 1'b0, tlb_multi = 1'b0;
    logic [31:0] tlb_ppn = '0;
    logic [1:0]  tlb_size = '0;
    logic        tlb_user = 1'b0, tlb_wr = 1'b0, tlb_dirty = 1'b0;
    logic        pteh_wr_en = 1'b0;
    logic [31:0] pteh_wr_data = '0;
    logic        res_valid;
    logic [31:0] res_pa;
    logic [6:0]  res_exc;
    logic [31:0] fault_addr, pteh;

    always #(CLK_P/2) clk = ~clk;

    va_access_chk u_va_access_chk (.*);

    typedef struct {
        logic [31:0] pa;
        logic [6:0]  exc;
        logic [31:0] fa;
        logic [31:0] ph;
        string       tag;
    } item_t;

    item_t       sbq[$];
    int          n_chk = 0;
    int          n_bad = 0;
    logic [31:0] m_fa = '0;
    logic [31:0] m_ph = '0;
    bit          done = 1'b0;

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Reference rules written from the requirements
    task automatic model(input logic [31:0] va, input int kind, input bit priv,
                         input bit at, input bit sq, input bit hit, input bit multi,
                         input logic [31:0] ppn, input int sz, input bit u, input bit w,
                         input bit d, output logic [31:0] pa, output logic [6:0] exc,
                         output bit xl);
        int r;
        int sh;
        logic [31:0] lo;
        exc = '0;
        pa  = va;
        if (va >= 32'h8000_0000) begin
            if (priv) begin
                if (kind == 2) r = (va < 32'hC000_0000) ? 0 : (va >= 32'hE000_0000) ? 2 : 1;
                else           r = (va < 32'hC000_0000 || va >= 32'hE000_0000) ? 0 : 1;
            end else begin
                r = (kind != 2 && va >= 32'hE000_0000 && va < 32'hE400_0000 && !sq) ? 0 : 2;
            end
        end else r = 1;
        if (r == 1 && !at) r = 0;
        xl = (r == 1);
        if (r == 2) begin
            exc = 7'b1000000; pa = '0;
        end else if (r == 1) begin
            if (!hit)                            exc = (kind == 1) ? 7'b0000010 : 7'b0000001;
            else if (multi)                      exc = 7'b0100000;
            else if (kind == 1 && !(w && (priv || u))) exc = 7'b0001000;
            else if (kind == 1 && !d)            exc = 7'b0010000;
            else if (kind != 1 && !priv && !u)   exc = 7'b0000100;
            if (exc != 0) pa = '0;
            else begin
                sh = (sz == 0) ? 10 : (sz == 1) ? 12 : (sz == 2) ? 16 : 20;
                lo = (32'd1 << sh) - 32'd1;
                pa = (ppn & ~lo) | (va & lo);
            end
        end
    endtask

    task automatic apply(input logic [31:0] va, input int kind, input bit priv,
                         input bit at, input bit sv, input bit sq, input bit hit,
                         input bit multi, input logic [31:0] ppn, input int sz,
                         input bit u, input bit w, input bit d, input string tag);
        item_t it;
        bit    xl;
        @(negedge clk);
        req_valid = 1'b1; req_va = va; req_kind = 2'(kind); req_priv = priv;
        ctl_at = at; ctl_sv = sv; ctl_sq_block = sq;
        tlb_hit = hit; tlb_multi = multi; tlb_ppn = ppn; tlb_size = 2'(sz);
        tlb_user = u; tlb_wr = w; tlb_dirty = d;
        model(va, kind, priv, at, sq, hit, multi, ppn, sz, u, w, d, it.pa, it.exc, xl);
        if (xl && it.exc[5:0] != 0) begin
            m_fa = va;
            m_ph = {va[31:10], m_ph[9:0]};
        end
        it.fa = m_fa; it.ph = m_ph; it.tag = tag;
        sbq.push_back(it);
        #1;
        chk(tlb_lookup == xl, {tag, " R5 lookup"}, 32'(tlb_lookup), 32'(xl));
        if (xl) chk(tlb_asid_en == (!sv || !priv), {tag, " R5 asid"}, 32'(tlb_asid_en), 32'(!sv || !priv));
    endtask

    task automatic idle();
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    // Monitor
    always @(negedge clk) begin
        if (!rst && res_valid) begin
            item_t e;
            if (sbq.size() == 0) begin
                chk(1'b0, "R13 unexpected result", 32'(res_valid), 32'd0);
            end else begin
                e = sbq.pop_front();
                chk(res_exc == e.exc, {e.tag, " exc"}, 32'(res_exc), 32'(e.exc));
                chk(res_pa == e.pa, {e.tag, " pa"}, res_pa, e.pa);
                chk(fault_addr == e.fa, {e.tag, " R11 fault_addr"}, fault_addr, e.fa);
                chk(pteh == e.ph, {e.tag, " R11 pteh"}, pteh, e.ph);
            end
        end
    end

    initial begin
        #(CLK_P * 100000);
        if (!done) begin
            chk(1'b0, "watchdog", 32'd0, 32'd1);
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R12 reset state
        chk(res_valid == 0, "R12 res_valid", 32'(res_valid), 0);
        chk(res_exc == 0, "R12 res_exc", 32'(res_exc), 0);
        chk(fault_addr == 0, "R12 fault_addr", fault_addr, 0);
        chk(pteh == 0, "R12 pteh", pteh, 0);

        //     va            k priv at sv sq hit mul ppn        sz u w d
        apply(32'h8000_1234, 0, 1, 1, 0, 0, 0, 0, 32'h0,       0, 0,0,0, "R1 p1 read");
        apply(32'hA123_4568, 1, 1, 1, 0, 0, 0, 0, 32'h0,       0, 0,0,0, "R1 p2 write");
        apply(32'hFF00_0010, 0, 1, 1, 0, 0, 0, 0, 32'h0,       0, 0,0,0, "R1 p4 read");
        apply(32'h9000_0000, 2, 1, 1, 0, 0, 0, 0, 32'h0,       0, 0,0,0, "R1 p1 fetch");
        apply(32'hE000_0000, 2, 1, 1, 0, 0, 0, 0, 32'h0,       0, 0,0,0, "R2 priv fetch p4");
        apply(32'h8000_0000, 0, 0, 1, 0, 0, 0, 0, 32'h0,       0, 0,0,0, "R2 user read p1");
        apply(32'hE3FF_FFFC, 1, 0, 1, 0, 0, 0, 0, 32'h0,       0, 0,0,0, "R3 user sq write");
        apply(32'hE400_0000, 0, 0, 1, 0, 0, 0, 0, 32'h0,       0, 0,0,0, "R3 user past window");
        apply(32'hE000_0000, 0, 0, 1, 0, 1, 0, 0, 32'h0,       0, 0,0,0, "R3 user sq blocked");
        apply(32'hE000_0000, 2, 0, 1, 0, 0, 0, 0, 32'h0,       0, 0,0,0, "R3 user sq fetch");
        apply(32'h0000_1000, 0, 0, 0, 0, 0, 0, 0, 32'h0,       0, 0,0,0, "R4 at off user");
        apply(32'hC000_0040, 1, 1, 0, 0, 0, 0, 0, 32'h0,       0, 0,0,0, "R4 at off p3");
        idle();
        @(negedge clk);
        pteh_wr_en = 1'b1; pteh_wr_data = 32'h0000_03A5;
        @(negedge clk);
        pteh_wr_en = 1'b0; m_ph = 32'h0000_03A5;
        apply(32'h0040_1234, 0, 0, 1, 0, 0, 0, 0, 32'h0,       0, 1,1,1, "R6 miss read");
        apply(32'h0055_5800, 1, 1, 1, 1, 0, 0, 0, 32'h0,       0, 1,1,1, "R6 miss write");
        apply(32'hC012_3400, 2, 1, 1, 1, 0, 0, 0, 32'h0,       0, 1,1,1, "R6 miss fetch");
        apply(32'h0001_0000, 1, 0, 1, 1, 0, 1, 1, 32'h0,       0, 0,0,0, "R6 multi over prot");
        apply(32'h0002_0000, 1, 0, 1, 0, 0, 1, 0, 32'h0,       1, 1,0,0, "R6 prot over dirty");
        apply(32'h0003_0000, 1, 1, 1, 0, 0, 1, 0, 32'h0,       1, 1,0,1, "R7 priv ro write");
        apply(32'h0004_0000, 1, 0, 1, 0, 0, 1, 0, 32'h0,       1, 0,1,1, "R7 user no-user write");
        apply(32'h8800_0000, 0, 0, 1, 0, 0, 0, 0, 32'h0,       0, 0,0,0, "R11 aerr keeps fault");
        apply(32'h0004_0004, 1, 1, 1, 0, 0, 1, 0, 32'h1000_0000,1, 0,1,1, "R7 priv write ok");
        apply(32'h0005_0000, 1, 1, 1, 0, 0, 1, 0, 32'h0,       1, 1,1,0, "R9 initial write");
        apply(32'h0006_0000, 0, 0, 1, 0, 0, 1, 0, 32'h0,       1, 0,1,1, "R8 user read no-user");
        apply(32'h0007_0000, 2, 0, 1, 0, 0, 1, 0, 32'h0,       1, 0,1,1, "R8 user fetch no-user");
        apply(32'hC006_0ABC, 0, 1, 1, 1, 0, 1, 0, 32'h0ABC_D000,1, 0,0,0, "R8 priv read no-user");
        apply(32'h1234_5678, 0, 0, 1, 0, 0, 1, 0, 32'h0ABC_DE00,0, 1,0,0, "R10 size 1K");
        apply(32'h1234_5678, 0, 0, 1, 0, 0, 1, 0, 32'h0ABC_DE00,1, 1,0,0, "R10 size 4K");
        apply(32'h1234_5678, 0, 0, 1, 0, 0, 1, 0, 32'h0ABC_DE00,2, 1,0,0, "R10 size 64K");
        apply(32'h1234_5678, 2, 0, 1, 0, 0, 1, 0, 32'h0ABC_DE00,3, 1,0,0, "R10 size 1M");
        idle();
        repeat (3) @(negedge clk);
        chk(sbq.size() == 0, "R13 results outstanding", 32'(sbq.size()), 0);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule